// File: doc/BRIEF.md
# Serial-Loaded Fault Injector for Internal Nodes

This block forces faults onto chosen internal nodes of a unit under test, so that the behaviour of the surrounding logic can be observed while a fault is present. A fault command is shifted in one bit at a time through a serial input. The command names a target node, a fault model, a duration mode and a repetition period. A separate apply strobe transfers the command to the forcing logic, so a command that is only partly shifted in never disturbs the nodes.

Each of the N node paths runs through a forcing cell. An unselected cell, or a cell whose fault is not active in the current cycle, passes the functional input straight through with no register in the path. A selected cell can hold its node at 0, hold it at 1, or invert it. The fault can last a single cycle, recur once every period+1 cycles, or stay until it is replaced. A multi-node flag widens the fault from the indexed node to that node and the next one up.

Top module: `fault_inject_top`

## Requirements
- R1: The command register takes one bit from `ser_in` on each clock edge where `shift_en` is high, entering at the least significant end, so that the first bit shifted ends up as the most significant. The register holds its value when `shift_en` is low. The 18-bit command is laid out as follows: bits [17:13] node index, [12:11] fault type, [10:9] duration mode, [8:1] period, and [0] multi-node flag.
- R2: A shifted command has no effect on `node_out` until a clock edge that samples `apply` high. Only that edge transfers the command to the forcing logic.
- R3: The node index selects the matching output bit. Every unselected output equals its input.
- R4: With the multi-node flag set, the fault also covers node (index+1) mod N. Node N-1 therefore wraps to node 0.
- R5: The fault type codes are: 01 forces the node to 0, 10 forces it to 1, 11 inverts it, and 00 injects nothing.
- R6: Duration mode 01 makes the fault active only during the single cycle that follows the apply edge.
- R7: Duration mode 10 with a period P of 1 or more makes the fault active in cycles 1, P+2, 2P+3, and so on, counting the cycle after the apply edge as cycle 1.
- R8: Duration mode 10 with a period of 0 behaves as a permanent fault.
- R9: Duration mode 11 keeps the fault active in every cycle until the next apply.
- R10: While no fault is active, `node_out` equals `node_in` on every bit.
- R11: Applying an all-zero command removes every active fault from the cycle that follows the apply edge.
- R12: After reset, no fault is active and `node_out` equals `node_in`.
- R13: Duration mode 00 injects nothing, whatever fault type is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial command data, most significant bit first |
| shift_en | input | 1 | Shift enable for the command register |
| apply | input | 1 | Strobe that transfers the shifted command to the forcing logic |
| node_in | input | N (32) | Functional node values |
| node_out | output | N (32) | Node values after forcing |

## Verification
The table-driven tests apply all-ones, all-zero and alternating input words under each fault type. This shows whether the type code is decoded correctly, and whether a neighbouring bit was hit by mistake. Index 31 with the multi-node flag set separates correct wraparound from a plain increment. The directed tests then follow the fault cycle by cycle after each apply. This tells single-cycle, periodic with a non-zero period, periodic with a zero period, and held faults apart. A command that is shifted but not applied, and idle toggling of the serial input with the shift enable low, show that only the apply strobe changes the nodes.

// File: rtl/fi_pkg.sv
package fi_pkg;

  typedef enum logic [1:0] {
    FT_NONE  = 2'b00,
    FT_LOW   = 2'b01,
    FT_HIGH  = 2'b10,
    FT_FLIP  = 2'b11
  } fault_t;

  typedef enum logic [1:0] {
    DM_OFF    = 2'b00,
    DM_ONCE   = 2'b01,
    DM_REPEAT = 2'b10,
    DM_HOLD   = 2'b11
  } dur_t;

  // Value a node takes once its fault is active.
  function automatic logic forced_bit(input fault_t ft, input logic v);
    case (ft)
      FT_LOW:  forced_bit = 1'b0;
      FT_HIGH: forced_bit = 1'b1;
      FT_FLIP: forced_bit = ~v;
      default: forced_bit = v;
    endcase
  endfunction

  // Index of the neighbouring node, with wraparound.
  function automatic int unsigned next_node(input int unsigned idx, input int unsigned n);
    next_node = (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/fi_cmd_shift.sv
module fi_cmd_shift #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         shift_en,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], ser_in};
  end
endmodule

// File: rtl/fi_decoder.sv
module fi_decoder #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             multi,
  input  logic             enable,
  output logic [N-1:0]     mask
);
  import fi_pkg::*;

  always_comb begin
    mask = '0;
    if (enable && (int'(idx) < N)) begin
      mask[idx] = 1'b1;
      if (multi) mask[next_node(int'(idx), N)] = 1'b1;
    end
  end
endmodule

// File: rtl/fi_arm.sv
module fi_arm #(
  parameter int N     = 32,
  parameter int PER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [N-1:0]      mask_in,
  input  fi_pkg::fault_t    ftype_in,
  input  fi_pkg::dur_t      mode_in,
  input  logic [PER_W-1:0]  period_in,
  output logic [N-1:0]      mask_q,
  output fi_pkg::fault_t    ftype_q,
  output fi_pkg::dur_t      mode_q,
  output logic [PER_W-1:0]  period_q,
  output logic              live
);
  import fi_pkg::*;

  logic [PER_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      ftype_q  <= FT_NONE;
      mode_q   <= DM_OFF;
      period_q <= '0;
      phase    <= '0;
    end else if (apply) begin
      mask_q   <= mask_in;
      ftype_q  <= ftype_in;
      mode_q   <= mode_in;
      period_q <= period_in;
      phase    <= '0;
    end else begin
      if (mode_q == DM_ONCE) mode_q <= DM_OFF;
      if (mode_q == DM_REPEAT) phase <= (phase >= period_q) ? '0 : phase + 1'b1;
    end
  end

  always_comb begin
    live = (mode_q != DM_OFF) && (ftype_q != FT_NONE);
    if (mode_q == DM_REPEAT) live = live && (phase == '0);
  end
endmodule

// File: rtl/fi_force_cell.sv
module fi_force_cell (
  input  logic           sel,
  input  logic           live,
  input  fi_pkg::fault_t ftype,
  input  logic           d,
  output logic           q
);
  import fi_pkg::*;

  assign q = (sel && live) ? forced_bit(ftype, d) : d;
endmodule

// File: rtl/fault_inject_top.sv
module fault_inject_top #(
  parameter int N     = 32,
  parameter int PER_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         shift_en,
  input  logic         apply,
  input  logic [N-1:0] node_in,
  output logic [N-1:0] node_out
);
  import fi_pkg::*;

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int CMD_W = IDX_W + 2 + 2 + PER_W + 1;
  localparam int P_LO  = 1;
  localparam int M_LO  = P_LO + PER_W;
  localparam int T_LO  = M_LO + 2;
  localparam int I_LO  = T_LO + 2;

  logic [CMD_W-1:0] cmd_word;
  logic [N-1:0]     dec_mask;
  logic [N-1:0]     sel_mask;
  fault_t           ftype_new, ftype_q;
  dur_t             mode_new, mode_q;
  logic [PER_W-1:0] period_q;
  logic             fault_live;
  logic             dec_en;

  fi_cmd_shift #(.W(CMD_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en), .word(cmd_word)
  );

  assign ftype_new = fault_t'(cmd_word[T_LO +: 2]);
  assign mode_new  = dur_t'(cmd_word[M_LO +: 2]);
  assign dec_en    = (ftype_new != FT_NONE) && (mode_new != DM_OFF);

  fi_decoder #(.N(N), .IDX_W(IDX_W)) dec_i (
    .idx(cmd_word[I_LO +: IDX_W]), .multi(cmd_word[0]), .enable(dec_en), .mask(dec_mask)
  );

  fi_arm #(.N(N), .PER_W(PER_W)) arm_i (
    .clk(clk), .rst_n(rst_n), .apply(apply),
    .mask_in(dec_mask), .ftype_in(ftype_new), .mode_in(mode_new),
    .period_in(cmd_word[P_LO +: PER_W]),
    .mask_q(sel_mask), .ftype_q(ftype_q), .mode_q(mode_q),
    .period_q(period_q), .live(fault_live)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    fi_force_cell cell_i (
      .sel(sel_mask[g]), .live(fault_live), .ftype(ftype_q),
      .d(node_in[g]), .q(node_out[g])
    );
  end
endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int N     = 32,
  parameter int PER_W = 8,
  parameter int CMD_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             apply,
  input logic [CMD_W-1:0] cmd_word,
  input logic [N-1:0]     sel_mask,
  input logic [1:0]       ftype_q,
  input logic [1:0]       mode_q,
  input logic [PER_W-1:0] period_q,
  input logic             fault_live,
  input logic [N-1:0]     node_in,
  input logic [N-1:0]     node_out
);
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cmd_word)); // R1
  AST_APPLY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(sel_mask)); // R2
  AST_STUCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_live && ftype_q == 2'b10) |-> ((node_out & sel_mask) == sel_mask)); // R5
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_live && mode_q == 2'b01 && !apply) |=> !fault_live); // R6
  AST_PERIOD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_live && mode_q == 2'b10 && period_q != '0 && !apply) |=> !fault_live); // R7
  AST_HOLD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_live && mode_q == 2'b11 && !apply) |=> fault_live); // R9
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_live |-> (node_out == node_in)); // R10
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && cmd_word == '0) |=> (!fault_live && sel_mask == '0)); // R11
endmodule

bind fault_inject_top fi_checker #(.N(N), .PER_W(PER_W), .CMD_W(CMD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .apply(apply),
  .cmd_word(cmd_word), .sel_mask(sel_mask), .ftype_q(ftype_q), .mode_q(mode_q),
  .period_q(period_q), .fault_live(fault_live), .node_in(node_in), .node_out(node_out)
);

// File: tb/fault_inject_top_tb.sv
module fault_inject_top_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic shift_en = 1'b0;
  logic apply = 1'b0;
  logic [N-1:0] node_in = '0;
  logic [N-1:0] node_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fault_inject_top dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
    .apply(apply), .node_in(node_in), .node_out(node_out)
  );

  // Field order: index, type, mode, period, multi.
  function automatic logic [17:0] mk(input int idx, input logic [1:0] ty,
                                     input logic [1:0] md, input int per, input bit mul);
    mk = {idx[4:0], ty, md, per[7:0], mul};
  endfunction

  // Each entry: command, input word, expected output one cycle after apply.
  localparam logic [81:0] VEC [0:6] = '{
    {5'd3,  2'b01, 2'b11, 8'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFF7},
    {5'd0,  2'b10, 2'b11, 8'd0, 1'b0, 32'h0000_0000, 32'h0000_0001},
    {5'd31, 2'b11, 2'b11, 8'd0, 1'b1, 32'h0000_0000, 32'h8000_0001},
    {5'd7,  2'b10, 2'b11, 8'd0, 1'b1, 32'h0000_0000, 32'h0000_0180},
    {5'd16, 2'b11, 2'b11, 8'd0, 1'b0, 32'hA5A5_A5A5, 32'hA5A4_A5A5},
    {5'd5,  2'b00, 2'b11, 8'd0, 1'b0, 32'h1234_5678, 32'h1234_5678},
    {5'd5,  2'b10, 2'b00, 8'd0, 1'b0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [N-1:0] exp);
    checks++;
    if (node_out !== exp) begin
      fails++;
      $display("FAIL %s: node_out=%h expected=%h", req, node_out, exp);
    end
  endtask

  task automatic load_cmd(input logic [17:0] w);
    for (int b = 17; b >= 0; b--) begin
      @(negedge clk);
      shift_en = 1'b1;
      ser_in   = w[b];
    end
    @(negedge clk);
    shift_en = 1'b0;
    ser_in   = 1'b0;
  endtask

  // Pulse apply for one edge, then sit in cycle 1 after the apply edge.
  task automatic fire();
    apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    #1;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    node_in = 32'hDEAD_BEEF;
    #35;
    check("R12 reset pass-through", 32'hDEAD_BEEF);
    rst_n = 1'b1;
    next_cycle();
    check("R12 after reset release", 32'hDEAD_BEEF);

    // Table walk: fault types, multi flag, wraparound, unselected bits.
    for (int k = 0; k < 7; k++) begin
      load_cmd(VEC[k][81:64]);
      node_in = VEC[k][63:32];
      fire();
      check("R3/R4/R5/R13 table", VEC[k][31:0]);
    end

    // R11: all-zero command clears.
    load_cmd(18'd0);
    node_in = 32'h0000_0000;
    fire();
    check("R11 clear", 32'h0000_0000);

    // R2: shifted but not applied.
    node_in = 32'hFFFF_FFFF;
    load_cmd(mk(0, 2'b01, 2'b11, 0, 1'b0));
    next_cycle();
    check("R2 no effect before apply", 32'hFFFF_FFFF);
    fire();
    check("R2 effect after apply", 32'hFFFF_FFFE);

    // R1: serial toggling with shift_en low leaves the command intact.
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      ser_in = c[0];
    end
    ser_in = 1'b0;
    fire();
    check("R1 hold while shift_en low", 32'hFFFF_FFFE);

    // R6: single cycle.
    node_in = '0;
    load_cmd(mk(1, 2'b10, 2'b01, 0, 1'b0));
    fire();
    check("R6 one-shot cycle 1", 32'h0000_0002);
    next_cycle();
    check("R6 one-shot cycle 2", 32'h0000_0000);
    next_cycle();
    check("R6 one-shot cycle 3", 32'h0000_0000);

    // R7: period 3 -> cycles 1,5,9.
    load_cmd(mk(4, 2'b10, 2'b10, 3, 1'b0));
    fire();
    for (int c = 1; c <= 9; c++) begin
      if (c > 1) next_cycle();
      check("R7 periodic", (c % 4 == 1) ? 32'h0000_0010 : 32'h0);
    end

    // R8: period zero acts as permanent.
    load_cmd(mk(9, 2'b10, 2'b10, 0, 1'b0));
    fire();
    for (int c = 1; c <= 5; c++) begin
      if (c > 1) next_cycle();
      check("R8 zero period", 32'h0000_0200);
    end

    // R9: permanent fault held for many cycles.
    node_in = 32'hFFFF_FFFF;
    load_cmd(mk(30, 2'b11, 2'b11, 0, 1'b1));
    fire();
    for (int c = 0; c < 50; c++) next_cycle();
    check("R9 held fault", 32'h3FFF_FFFF);

    // R10/R11: clear then pass-through of varying data.
    load_cmd(18'd0);
    fire();
    check("R11 clear after hold", 32'hFFFF_FFFF);
    node_in = 32'h5A5A_0F0F;
    #1;
    check("R10 pass-through", 32'h5A5A_0F0F);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule